// File: doc/BRIEF.md
# Dual-Strobe Page DRAM Control Decoder

This block is the control logic on the device side of an asynchronous DRAM with a multiplexed 10-bit address bus and two byte-lane column strobes. The row and column strobes, write enable and output enable arrive as asynchronous active-low signals. A fast sampling clock brings them into its own domain, and edges are found on the sampled copies. A row-strobe fall takes the bus as a row. The first column-strobe fall after it takes the bus as a column.

The two byte strobes merge into one internal column strobe. It goes active when the first byte strobe falls and goes inactive only when both are high again. Each byte strobe still gates its own 8-bit lane, for both reads and writes.

The decoder sorts each row cycle into one of two kinds:
- An access, which is a read, an early write or a late write.
- An internal-counter refresh, chosen when a column strobe is already low at the row-strobe fall.

Every row cycle reports the row it refreshed. Storage is a small behavioural array that uses the low bits of the row and column addresses.

Top module: `dram_strobe_ctl`

## Requirements
- R1: A row-strobe fall with both column strobes high captures `addr_i` as the row. The next column-strobe fall captures `addr_i` as the column. A later read of the same row and column returns the word written there.
- R2: The internal column strobe asserts on the first byte-strobe fall and releases only when both byte strobes are high. A second byte strobe falling while the first is still low does not re-capture the column. A lane stays driven until its own strobe rises.
- R3: Lane 0 is bits 7:0 and follows `lcas_n_i`. Lane 1 is bits 15:8 and follows `ucas_n_i`. A write changes only the lanes whose strobe is low at the write moment. In `drive_o`, bit 0 is lane 0 and bit 1 is lane 1.
- R4: When `we_n_i` is already low at the column-strobe fall (early write), `din_i` is written at that moment. Both lanes of `drive_o` then stay 0 until the column strobe rises, even with output enable low and write enable back high.
- R5: A write-enable fall while the column strobe is low in an access that has not yet written (late write) writes `din_i` at that moment.
- R6: A lane drives (`drive_o` bit 1, data on `dout_o`) only when all of the following hold: an access row cycle is open, the row strobe is low, the lane's strobe is low, output enable is low, write enable is high, and the cycle is not an early write. Raising output enable floats the lane. A lane that is not driven reads 0 on `dout_o`.
- R7: A column strobe low at the row-strobe fall starts a refresh from the internal counter. `ref_o` pulses once and `ref_row_o` equals the counter value. `addr_i` is ignored, nothing is written and `drive_o` stays 0.
- R8: The refresh counter starts at 0 after reset. It advances by one when each counter-refresh row cycle ends and wraps from 1023 to 0.
- R9: Every row-strobe fall with both column strobes high pulses `ref_o` once with `ref_row_o` equal to the row on `addr_i`, including a row cycle with no column strobe.
- R10: After reset, `drive_o`, `dout_o`, `lane_we_o`, `ref_o` and `ref_row_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n_i | input | 1 | Row strobe, active low, asynchronous |
| lcas_n_i | input | 1 | Lower-lane column strobe, active low |
| ucas_n_i | input | 1 | Upper-lane column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| din_i | input | 16 | Write data |
| dout_o | output | 16 | Read data, 0 on lanes not driven |
| drive_o | output | 2 | Per-lane output drive enable |
| lane_we_o | output | 2 | Per-lane write strobe into the array |
| ref_o | output | 1 | One-cycle pulse per refreshed row |
| ref_row_o | output | 10 | Row refreshed by the last row cycle |

## Verification
A wrong access kind shows at the ports within about five sampling cycles of the column-strobe fall. A cycle mistaken for an early write leaves `drive_o` low when it should drive. A missed early write drives data during a write. A stale column register or a lost lane mask only shows on the next read of the affected word, as wrong bytes in one lane. A counter fault shows on `ref_row_o` at the next counter refresh, and a wrap fault shows only after the 1024th refresh. For that reason the bench runs the full counter range.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // kind of the open row cycle
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_ACCESS = 2'd1,
    MODE_CNTREF = 2'd2
  } mode_e;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_V}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_ras_n,
  input  logic [LANES-1:0]  s_cas_n,
  input  logic              s_we_n,
  input  logic              s_oe_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic [LANES-1:0]  drive_o,
  output logic              ref_o,
  output logic [ADDR_W-1:0] ref_row_o
);
  mode_e             mode_q, mode_d;
  logic [ADDR_W-1:0] row_q, row_d, col_q, col_d, cnt_q, cnt_d, rrow_q, rrow_d;
  logic              colv_q, colv_d, early_q, early_d, wrote_q, wrote_d;
  logic [LANES-1:0]  lwe_q, lwe_d;
  logic              ref_q, ref_d;
  logic              p_ras_q, p_cas_q, p_we_q;

  logic cas_act, ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  assign cas_act  = ~&s_cas_n;
  assign ras_fall = p_ras_q & ~s_ras_n;
  assign ras_rise = ~p_ras_q & s_ras_n;
  assign cas_fall = ~p_cas_q & cas_act;
  assign cas_rise = p_cas_q & ~cas_act;
  assign we_fall  = p_we_q & ~s_we_n;

  always_comb begin
    mode_d  = mode_q;
    row_d   = row_q;
    col_d   = col_q;
    cnt_d   = cnt_q;
    rrow_d  = rrow_q;
    colv_d  = colv_q;
    early_d = early_q;
    wrote_d = wrote_q;
    lwe_d   = '0;
    ref_d   = 1'b0;
    if (ras_rise) begin
      if (mode_q == MODE_CNTREF) cnt_d = cnt_q + 1'b1;
      mode_d  = MODE_IDLE;
      colv_d  = 1'b0;
      early_d = 1'b0;
      wrote_d = 1'b0;
    end else if (ras_fall) begin
      ref_d = 1'b1;
      if (cas_act) begin
        mode_d = MODE_CNTREF;
        rrow_d = cnt_q;
      end else begin
        mode_d = MODE_ACCESS;
        row_d  = addr_i;
        rrow_d = addr_i;
      end
    end else if (mode_q == MODE_ACCESS) begin
      if (cas_fall) begin
        col_d  = addr_i;
        colv_d = 1'b1;
        if (!s_we_n) begin
          early_d = 1'b1;
          wrote_d = 1'b1;
          lwe_d   = ~s_cas_n;
        end
      end else if (cas_rise) begin
        colv_d  = 1'b0;
        early_d = 1'b0;
        wrote_d = 1'b0;
      end else if (colv_q && cas_act && we_fall && !wrote_q) begin
        lwe_d   = ~s_cas_n;
        wrote_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      cnt_q   <= '0;
      rrow_q  <= '0;
      colv_q  <= 1'b0;
      early_q <= 1'b0;
      wrote_q <= 1'b0;
      lwe_q   <= '0;
      ref_q   <= 1'b0;
      p_ras_q <= 1'b1;
      p_cas_q <= 1'b0;
      p_we_q  <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      row_q   <= row_d;
      col_q   <= col_d;
      cnt_q   <= cnt_d;
      rrow_q  <= rrow_d;
      colv_q  <= colv_d;
      early_q <= early_d;
      wrote_q <= wrote_d;
      lwe_q   <= lwe_d;
      ref_q   <= ref_d;
      p_ras_q <= s_ras_n;
      p_cas_q <= cas_act;
      p_we_q  <= s_we_n;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_drv
    assign drive_o[g] = (mode_q == MODE_ACCESS) & colv_q & ~early_q & ~s_ras_n
                        & ~s_cas_n[g] & ~s_oe_n & s_we_n;
  end

  assign row_o     = row_q;
  assign col_o     = col_q;
  assign lane_we_o = lwe_q;
  assign ref_o     = ref_q;
  assign ref_row_o = rrow_q;

  AST_CNTREF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CNTREF) |-> (lwe_q == '0)); // R7
  AST_CNTREF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CNTREF) |-> (drive_o == '0)); // R7
  AST_COUNTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == ADDR_W'($past(cnt_q) + 1'b1))); // R8
  AST_EARLY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    early_q |-> (drive_o == '0)); // R4
  AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q |=> !ref_q); // R9
  AST_LANE_WE_OWN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (lwe_d != '0) |-> ((lwe_d & s_cas_n) == '0)); // R3
endmodule

// File: rtl/dsc_array.sv
module dsc_array #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int LANES    = 2,
  parameter int LANE_W   = 8
) (
  input  logic                      clk,
  input  logic [ROW_BITS-1:0]       row_i,
  input  logic [COL_BITS-1:0]       col_i,
  input  logic [LANES-1:0]          we_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o
);
  localparam int AW    = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] idx;
  assign idx = {row_i, col_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we_i[g]) mem[idx] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[idx];
  end
endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
  parameter int ADDR_W   = 10,
  parameter int LANE_W   = 8,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n_i,
  input  logic              lcas_n_i,
  input  logic              ucas_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2*LANE_W-1:0] din_i,
  output logic [2*LANE_W-1:0] dout_o,
  output logic [1:0]        drive_o,
  output logic [1:0]        lane_we_o,
  output logic              ref_o,
  output logic [ADDR_W-1:0] ref_row_o
);
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [4:0] raw_in, syn;
  assign raw_in = {oe_n_i, we_n_i, ucas_n_i, lcas_n_i, ras_n_i};

  dsc_sync #(.W(5), .STAGES(2), .RST_V(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  logic [ADDR_W-1:0] row_q, col_q;
  logic [LANES-1:0]  lwe, drv;

  dsc_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .s_ras_n   (syn[0]),
    .s_cas_n   (syn[2:1]),
    .s_we_n    (syn[3]),
    .s_oe_n    (syn[4]),
    .addr_i    (addr_i),
    .row_o     (row_q),
    .col_o     (col_q),
    .lane_we_o (lwe),
    .drive_o   (drv),
    .ref_o     (ref_o),
    .ref_row_o (ref_row_o)
  );

  logic [DATA_W-1:0] rdata;
  dsc_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .row_i   (row_q[ROW_BITS-1:0]),
    .col_i   (col_q[COL_BITS-1:0]),
    .we_i    (lwe),
    .wdata_i (din_i),
    .rdata_o (rdata)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dout_o[g*LANE_W +: LANE_W] = drv[g] ? rdata[g*LANE_W +: LANE_W] : '0;
  end
  assign drive_o   = drv;
  assign lane_we_o = lwe;

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (drv != '0) |-> !syn[4]); // R6
  AST_NO_DRIVE_WHILE_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lwe != '0) |-> (drv == '0)); // R4
endmodule

// File: tb/dram_strobe_ctl_tb.sv
module dram_strobe_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras = 1'b1, lc = 1'b1, uc = 1'b1, we = 1'b1, oe = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  drive, lwe;
  logic        refp;
  logic [9:0]  ref_row;

  int checks = 0, errors = 0;
  int ref_cnt = 0;
  logic [9:0] last_ref = '0;
  bit done = 0;

  always #5ns clk = ~clk;

  dram_strobe_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n_i(ras), .lcas_n_i(lc), .ucas_n_i(uc),
    .we_n_i(we), .oe_n_i(oe), .addr_i(addr), .din_i(din), .dout_o(dout),
    .drive_o(drive), .lane_we_o(lwe), .ref_o(refp), .ref_row_o(ref_row)
  );

  always @(posedge clk) if (refp) begin ref_cnt++; last_ref = ref_row; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input logic r, input logic l, input logic u, input logic w,
                     input logic o, input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    ras = r; lc = l; uc = u; we = w; oe = o; addr = a; din = d;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] ln, input logic [9:0] row,
                          input logic [9:0] col, input logic [15:0] d);
    drv(0, 1, 1, 1, 1, row, d);
    drv(0, 1, 1, 0, 1, col, d);
    drv(0, ~ln[0], ~ln[1], 0, 0, col, d);
    check("R4 early write floats with OE low", {30'd0, drive}, 0);
    drv(0, ~ln[0], ~ln[1], 1, 0, col, d);
    check("R4 early write floats after WE high", {30'd0, drive}, 0);
    drv(0, 1, 1, 1, 1, col, d);
    drv(1, 1, 1, 1, 1, 10'd0, d);
  endtask

  task automatic do_read(input logic [1:0] ln, input logic [9:0] row,
                         input logic [9:0] col, input logic [15:0] exp);
    drv(0, 1, 1, 1, 1, row, 16'h0);
    drv(0, 1, 1, 1, 0, col, 16'h0);
    drv(0, ~ln[0], ~ln[1], 1, 0, col, 16'h0);
    check("R1 R3 read data", {16'd0, dout}, {16'd0, exp});
    check("R3 R6 lane drive", {30'd0, drive}, {30'd0, ln});
    drv(0, ~ln[0], ~ln[1], 1, 1, col, 16'h0);
    check("R6 OE high floats", {30'd0, drive}, 0);
    drv(0, 1, 1, 1, 1, col, 16'h0);
    drv(1, 1, 1, 1, 1, 10'd0, 16'h0);
  endtask

  // {kind(1=read), lanes, row, col, write data, expected read}
  localparam logic [54:0] VEC [0:7] = '{
    {1'b0, 2'b11, 10'd5, 10'd3, 16'hA1B2, 16'h0000},
    {1'b1, 2'b11, 10'd5, 10'd3, 16'h0000, 16'hA1B2},
    {1'b0, 2'b01, 10'd5, 10'd3, 16'hFFCC, 16'h0000},
    {1'b1, 2'b11, 10'd5, 10'd3, 16'h0000, 16'hA1CC},
    {1'b0, 2'b10, 10'd2, 10'd7, 16'h5A77, 16'h0000},
    {1'b1, 2'b10, 10'd2, 10'd7, 16'h0000, 16'h5A00},
    {1'b0, 2'b11, 10'd1, 10'd0, 16'h1234, 16'h0000},
    {1'b1, 2'b11, 10'd1, 10'd0, 16'h0000, 16'h1234}
  };

  initial begin
    #1ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R10 reset state
    check("R10 drive after reset", {30'd0, drive}, 0);
    check("R10 dout after reset", {16'd0, dout}, 0);
    check("R10 lane_we after reset", {30'd0, lwe}, 0);
    check("R10 ref_row after reset", {22'd0, ref_row}, 0);
    check("R10 no ref pulse", ref_cnt, 0);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][54]) do_read(VEC[i][53:52], VEC[i][51:42], VEC[i][41:32], VEC[i][15:0]);
      else            do_write(VEC[i][53:52], VEC[i][51:42], VEC[i][41:32], VEC[i][31:16]);
    end

    // R9 row-only refresh
    rc = ref_cnt;
    drv(0, 1, 1, 1, 0, 10'h155, 16'h0);
    check("R9 row-only ref row", {22'd0, last_ref}, 32'h155);
    check("R9 single ref pulse", ref_cnt, rc + 1);
    check("R9 row-only floats", {30'd0, drive}, 0);
    drv(1, 1, 1, 1, 1, 10'h0, 16'h0);

    // R2 merged strobe: column captured once on first lane fall
    do_write(2'b11, 10'd6, 10'd4, 16'h4444);
    do_write(2'b11, 10'd6, 10'd5, 16'h5555);
    drv(0, 1, 1, 1, 1, 10'd6, 16'h0);
    drv(0, 0, 1, 1, 0, 10'd4, 16'h0);
    check("R2 lower lane first", {16'd0, dout}, 32'h0044);
    drv(0, 0, 0, 1, 0, 10'd5, 16'h0);
    check("R2 no column recapture", {16'd0, dout}, 32'h4444);
    drv(0, 1, 0, 1, 0, 10'd5, 16'h0);
    check("R2 upper still driven", {30'd0, drive}, 32'h2);
    check("R2 upper data kept", {16'd0, dout}, 32'h4400);
    drv(0, 1, 1, 1, 0, 10'd5, 16'h0);
    check("R2 release on last rise", {30'd0, drive}, 0);
    drv(1, 1, 1, 1, 1, 10'd0, 16'h0);

    // R5 late write
    drv(0, 1, 1, 1, 1, 10'd3, 16'h0);
    drv(0, 0, 0, 1, 1, 10'd2, 16'hBEEF);
    check("R6 OE high no drive", {30'd0, drive}, 0);
    drv(0, 0, 0, 0, 1, 10'd2, 16'hBEEF);
    drv(0, 1, 1, 1, 1, 10'd2, 16'h0);
    drv(1, 1, 1, 1, 1, 10'd0, 16'h0);
    do_read(2'b11, 10'd3, 10'd2, 16'hBEEF);

    // R7 R8 counter refresh across full range
    for (int k = 0; k < 1025; k++) begin
      drv(1, 0, 0, 1, 0, 10'h2AA, 16'h0);
      drv(0, 0, 0, 1, 0, 10'h2AA, 16'h0);
      check("R7 R8 counter row", {22'd0, last_ref}, (k == 1024) ? 0 : k);
      if (k < 2) check("R7 refresh floats", {30'd0, drive}, 0);
      drv(1, 0, 0, 1, 0, 10'h2AA, 16'h0);
      drv(1, 1, 1, 1, 1, 10'h0, 16'h0);
    end

    // R7 refresh must not have written: earlier word intact
    do_read(2'b11, 10'd5, 10'd3, 16'hA1CC);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule